// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects the interrupt causes of a graphics engine and reduces them to a single interrupt line for the host. There are three causes. The binner signals that its last flush has finished. The renderer signals that a frame is complete. The binner can also run short of overflow memory. The first two arrive as one-cycle pulses and are held in the pending register until software acknowledges them. The third is a level condition. It is derived from a small pool-tracking state machine that records whether software has installed an overflow pool.

Software works through five word registers:

| Index | Register | Behaviour |
|---|---|---|
| 0 | Pending | Write ones to acknowledge (clear) pending bits |
| 1 | Mask-set | Write ones to enable causes |
| 2 | Mask-clear | Write ones to disable causes |
| 3 | Pool base | Overflow pool base address |
| 4 | Pool size | Overflow pool size |

Both mask registers read back the same live mask.

The pool state machine has three states:

- `POOL_EMPTY`: the reset state, meaning no pool is present.
- `POOL_ARMING`: a base address has been written.
- `POOL_READY`: a base and then a size have been written.

It has four transitions:

- `T_BASE`: from `POOL_EMPTY` to `POOL_ARMING`, on a base write.
- `T_SIZE`: from `POOL_ARMING` to `POOL_READY`, on a size write.
- `T_REBASE`: from `POOL_READY` to `POOL_ARMING`, on a base write.
- `T_DRAIN`: from `POOL_READY` to `POOL_EMPTY`, on the binner's pool-consumed pulse.

The out-of-memory condition is active in every state except `POOL_READY`. Because no pool exists after reset, out-of-memory is the cause that fires first once it is enabled.

Top module: `gpu_irq_ctrl`

## Requirements
- R1: While reset is asserted, the pending bits, the mask, the pool base, the pool size and the interrupt line are all 0.
- R2: A write to index 0 clears every flush-done (bit 0) or frame-done (bit 1) pending bit whose written bit is 1. Bits written as 0 keep their value.
- R3: A write to index 1 sets the mask bits written as 1. Bits written as 0 leave the mask unchanged. Mask bit positions are the same as pending bit positions.
- R4: A write to index 2 clears the mask bits written as 1. Bits written as 0 leave the mask unchanged.
- R5: Reads of index 1 and of index 2 both return the current mask in bits 2:0, with zeros above. A read of index 0 returns the pending bits. Unused indices 5 to 7 read as 0 and ignore writes.
- R6: A flush-done or frame-done pulse sets its pending bit whether or not that cause is enabled. If the pulse coincides with an acknowledge of the same bit, the bit stays set.
- R7: Pending bit 2 (out-of-memory) is set on every cycle in which the pool is not in `POOL_READY`. An acknowledge clears it for exactly one cycle, and it returns on the next cycle while the condition holds.
- R8: The pool leaves the out-of-memory condition only through a base write followed by a size write. A size write in `POOL_EMPTY` does not do so. A pool-consumed pulse in `POOL_READY` restores the condition.
- R9: The interrupt line is a register equal to the OR of (pending AND mask), one cycle after that value changes.
- R10: Indices 3 and 4 read back the last values written to them, and the same values drive the pool base and pool size outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Write strobe for the indexed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the indexed register (combinational) |
| flush_done_pulse | input | 1 | One-cycle pulse when the binner flush finishes |
| frame_done_pulse | input | 1 | One-cycle pulse when a frame render finishes |
| pool_consumed | input | 1 | One-cycle pulse when the binner has used up the current overflow pool |
| pool_base_o | output | DATA_W | Installed overflow pool base |
| pool_size_o | output | DATA_W | Installed overflow pool size |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The bench drives an acknowledge in the same cycle as a frame-done pulse. A design that let the clear win would lose that event. The bench also acknowledges out-of-memory while the pool is still empty. A design that treated that bit as a latched event would leave it clear. A design without a one-cycle clear would never drop the interrupt line between the acknowledge and the reassertion.

Mask writes with all-zero data check for a design that loads the mask instead of ORing or masking into it. A size write without a prior base write checks for a pool machine that accepts a size alone. Pending bits set while their mask is off, followed by enabling them, check the one-cycle lag of the registered interrupt line.

// File: rtl/gpu_irq_pkg.sv
`timescale 1ns/1ps
package gpu_irq_pkg;
    localparam int NUM_SRC   = 3;
    localparam int SRC_FLUSH = 0;
    localparam int SRC_FRAME = 1;
    localparam int SRC_OOM   = 2;
    localparam int ADDR_W    = 3;

    // Sources whose pending bit follows a level instead of latching a pulse
    localparam logic [NUM_SRC-1:0] LEVEL_SRCS = 3'b100;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PENDING   = 3'd0,
        SEL_MASK_SET  = 3'd1,
        SEL_MASK_CLR  = 3'd2,
        SEL_POOL_BASE = 3'd3,
        SEL_POOL_SIZE = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        POOL_EMPTY  = 2'd0,
        POOL_ARMING = 2'd1,
        POOL_READY  = 2'd2
    } pool_state_e;
endpackage

// File: rtl/gpu_irq_pool_fsm.sv
`timescale 1ns/1ps
module gpu_irq_pool_fsm
    import gpu_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic              size_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              consumed,
    output logic [DATA_W-1:0] pool_base,
    output logic [DATA_W-1:0] pool_size,
    output logic              starved
);
    pool_state_e       state_q;
    pool_state_e       state_d;
    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] size_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= POOL_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions T_BASE, T_SIZE, T_REBASE, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POOL_EMPTY:  if (base_wr) state_d = POOL_ARMING;
            POOL_ARMING: if (size_wr) state_d = POOL_READY;
            POOL_READY: begin
                if (base_wr)       state_d = POOL_ARMING;
                else if (consumed) state_d = POOL_EMPTY;
            end
            default:               state_d = POOL_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        starved = (state_q != POOL_READY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else begin
            if (base_wr) base_q <= wdata;
            if (size_wr) size_q <= wdata;
        end
    end

    assign pool_base = base_q;
    assign pool_size = size_q;
endmodule

// File: rtl/gpu_irq_status_bank.sv
`timescale 1ns/1ps
module gpu_irq_status_bank #(
    parameter int              N         = 3,
    parameter logic [N-1:0]    LEVEL_MSK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pending
);
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LEVEL_MSK[i]) begin : g_level
            // acknowledge wins for one cycle; level sets it again after
            always_ff @(posedge clk) begin
                if (!rst_n)      pend_q[i] <= 1'b0;
                else if (ack[i]) pend_q[i] <= 1'b0;
                else if (src[i]) pend_q[i] <= 1'b1;
            end
        end else begin : g_event
            // a new event beats a simultaneous acknowledge
            always_ff @(posedge clk) begin
                if (!rst_n)      pend_q[i] <= 1'b0;
                else if (src[i]) pend_q[i] <= 1'b1;
                else if (ack[i]) pend_q[i] <= 1'b0;
            end
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/gpu_irq_ctrl.sv
`timescale 1ns/1ps
module gpu_irq_ctrl
    import gpu_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flush_done_pulse,
    input  logic              frame_done_pulse,
    input  logic              pool_consumed,
    output logic [DATA_W-1:0] pool_base_o,
    output logic [DATA_W-1:0] pool_size_o,
    output logic              host_irq
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic               wr_pend, wr_mset, wr_mclr, wr_base, wr_size;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pending;
    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] ack_vec;
    logic               starved;
    logic               irq_q;

    assign wr_pend = bus_wr && (bus_addr == SEL_PENDING);
    assign wr_mset = bus_wr && (bus_addr == SEL_MASK_SET);
    assign wr_mclr = bus_wr && (bus_addr == SEL_MASK_CLR);
    assign wr_base = bus_wr && (bus_addr == SEL_POOL_BASE);
    assign wr_size = bus_wr && (bus_addr == SEL_POOL_SIZE);

    gpu_irq_pool_fsm #(.DATA_W(DATA_W)) pool_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_wr   (wr_base),
        .size_wr   (wr_size),
        .wdata     (bus_wdata),
        .consumed  (pool_consumed),
        .pool_base (pool_base_o),
        .pool_size (pool_size_o),
        .starved   (starved)
    );

    always_comb begin
        src_vec            = '0;
        src_vec[SRC_FLUSH] = flush_done_pulse;
        src_vec[SRC_FRAME] = frame_done_pulse;
        src_vec[SRC_OOM]   = starved;
        ack_vec            = wr_pend ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    gpu_irq_status_bank #(.N(NUM_SRC), .LEVEL_MSK(LEVEL_SRCS)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src_vec),
        .ack     (ack_vec),
        .pending (pending)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mset) begin
            mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
        end else if (wr_mclr) begin
            mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pending & mask_q);
    end
    assign host_irq = irq_q;

    always_comb begin
        case (bus_addr)
            SEL_PENDING:   bus_rdata = {{PAD_W{1'b0}}, pending};
            SEL_MASK_SET,
            SEL_MASK_CLR:  bus_rdata = {{PAD_W{1'b0}}, mask_q};
            SEL_POOL_BASE: bus_rdata = pool_base_o;
            SEL_POOL_SIZE: bus_rdata = pool_size_o;
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpu_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpu_irq_ctrl_chk
    import gpu_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               flush_done_pulse,
    input logic               frame_done_pulse,
    input logic               pool_consumed,
    input logic               host_irq,
    input logic [NUM_SRC-1:0] pending,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               starved
);
    p_ack_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_PENDING && bus_wdata[SRC_FLUSH] && !flush_done_pulse)
        |=> !pending[SRC_FLUSH]);

    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_MASK_SET)
        |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_MASK_CLR)
        |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == SEL_MASK_SET || bus_addr == SEL_MASK_CLR))
        |=> $stable(mask_q));

    p_flush_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done_pulse |=> pending[SRC_FLUSH]);

    p_frame_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_pulse |=> pending[SRC_FRAME]);

    p_oom_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (starved && !(bus_wr && bus_addr == SEL_PENDING && bus_wdata[SRC_OOM]))
        |=> pending[SRC_OOM]);

    p_oom_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_PENDING && bus_wdata[SRC_OOM])
        |=> !pending[SRC_OOM]);

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pool_consumed && !starved && !(bus_wr && bus_addr == SEL_POOL_BASE))
        |=> starved);

    p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pending & mask_q)) |=> host_irq);

    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(mask_q != '0));
endmodule

bind gpu_irq_ctrl gpu_irq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_addr         (bus_addr),
    .bus_wr           (bus_wr),
    .bus_wdata        (bus_wdata),
    .flush_done_pulse (flush_done_pulse),
    .frame_done_pulse (frame_done_pulse),
    .pool_consumed    (pool_consumed),
    .host_irq         (host_irq),
    .pending          (pending),
    .mask_q           (mask_q),
    .starved          (starved)
);

// File: tb/gpu_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpu_irq_ctrl_tb_top;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              flush_done_pulse = 1'b0;
    logic              frame_done_pulse = 1'b0;
    logic              pool_consumed = 1'b0;
    logic [DATA_W-1:0] pool_base_o;
    logic [DATA_W-1:0] pool_size_o;
    logic              host_irq;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    gpu_irq_ctrl #(.DATA_W(DATA_W)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_addr         (bus_addr),
        .bus_wr           (bus_wr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .flush_done_pulse (flush_done_pulse),
        .frame_done_pulse (frame_done_pulse),
        .pool_consumed    (pool_consumed),
        .pool_base_o      (pool_base_o),
        .pool_size_o      (pool_size_o),
        .host_irq         (host_irq)
    );

    typedef struct packed {
        logic       wr;
        logic [2:0] addr;
        logic [7:0] wdata;
        logic       fl;
        logic       fr;
        logic       cons;
        logic [2:0] chk;
        logic [7:0] exp;
        logic       irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd3, 8'h40, 1'b0, 1'b0, 1'b0, 3'd3, 8'h40, 1'b0, 4'd10}, // R10 base
        '{1'b1, 3'd4, 8'h10, 1'b0, 1'b0, 1'b0, 3'd4, 8'h10, 1'b0, 4'd8 }, // R8 pool ready
        '{1'b1, 3'd0, 8'h04, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 4'd7 }, // R7 ack, level gone
        '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 8'h01, 1'b0, 4'd6 }, // R6 latch while masked
        '{1'b1, 3'd1, 8'h01, 1'b0, 1'b0, 1'b0, 3'd1, 8'h01, 1'b1, 4'd9 }, // R9 enable pending
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd2, 8'h01, 1'b1, 4'd5 }, // R5 mask via clr index
        '{1'b1, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0, 3'd0, 8'h02, 1'b0, 4'd2 }, // R2 ack flush
        '{1'b1, 3'd1, 8'h02, 1'b0, 1'b0, 1'b0, 3'd2, 8'h03, 1'b1, 4'd3 }, // R3 set bit 1
        '{1'b1, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 3'd1, 8'h03, 1'b1, 4'd3 }, // R3 zeros ignored
        '{1'b1, 3'd2, 8'h02, 1'b0, 1'b0, 1'b0, 3'd1, 8'h01, 1'b0, 4'd4 }, // R4 clear bit 1
        '{1'b1, 3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 3'd2, 8'h01, 1'b0, 4'd4 }, // R4 zeros ignored
        '{1'b1, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, 8'h02, 1'b0, 4'd2 }, // R2 zeros ignored
        '{1'b1, 3'd0, 8'h02, 1'b0, 1'b1, 1'b0, 3'd0, 8'h02, 1'b0, 4'd6 }, // R6 event beats ack
        '{1'b1, 3'd0, 8'h02, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 4'd2 }, // R2 ack frame
        '{1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 3'd0, 8'h04, 1'b0, 4'd8 }, // R8 drain
        '{1'b1, 3'd1, 8'h04, 1'b0, 1'b0, 1'b0, 3'd1, 8'h05, 1'b1, 4'd9 }, // R9 oom enabled
        '{1'b1, 3'd0, 8'h04, 1'b0, 1'b0, 1'b0, 3'd0, 8'h04, 1'b0, 4'd7 }, // R7 reasserts, irq dips
        '{1'b1, 3'd4, 8'h20, 1'b0, 1'b0, 1'b0, 3'd4, 8'h20, 1'b1, 4'd8 }, // R8 size alone
        '{1'b1, 3'd3, 8'h80, 1'b0, 1'b0, 1'b0, 3'd3, 8'h80, 1'b1, 4'd8 }, // R8 base
        '{1'b1, 3'd4, 8'h30, 1'b0, 1'b0, 1'b0, 3'd4, 8'h30, 1'b1, 4'd8 }, // R8 size completes
        '{1'b1, 3'd0, 8'h04, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 4'd7 }, // R7 ack sticks
        '{1'b1, 3'd5, 8'hFF, 1'b0, 1'b0, 1'b0, 3'd5, 8'h00, 1'b0, 4'd5 }  // R5 unused index
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_addr = 3'd0;
        #0.1 check("R1 pending", bus_rdata, 0);
        bus_addr = 3'd1;
        #0.1 check("R1 mask", bus_rdata, 0);
        check("R1 irq", {31'd0, host_irq}, 0);
        check("R1 base", pool_base_o, 0);
        check("R1 size", pool_size_o, 0);

        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 3'd0;
        #0.1 check("R7 power-on oom", bus_rdata, 32'h4);
        check("R9 masked oom", {31'd0, host_irq}, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr           = VECS[i].wr;
            bus_addr         = VECS[i].addr;
            bus_wdata        = {24'd0, VECS[i].wdata};
            flush_done_pulse = VECS[i].fl;
            frame_done_pulse = VECS[i].fr;
            pool_consumed    = VECS[i].cons;
            @(negedge clk);
            bus_wr           = 1'b0;
            flush_done_pulse = 1'b0;
            frame_done_pulse = 1'b0;
            pool_consumed    = 1'b0;
            bus_wdata        = '0;
            bus_addr         = VECS[i].chk;
            @(negedge clk);
            check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), bus_rdata,
                  {24'd0, VECS[i].exp});
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'd0, host_irq},
                  {31'd0, VECS[i].irq});
        end

        // R10 pool outputs carry last written values
        check("R10 base out", pool_base_o, 32'h80);
        check("R10 size out", pool_size_o, 32'h30);

        // R9 lag: enabling a pending bit raises the line one cycle after the mask changes
        @(negedge clk);
        flush_done_pulse = 1'b1;
        @(negedge clk);
        flush_done_pulse = 1'b0;
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h7;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        check("R9 before lag", {31'd0, host_irq}, 0);
        @(negedge clk);
        check("R9 after lag", {31'd0, host_irq}, 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule